// File: doc/BRIEF.md
# Auto-Reload Timer with External Trigger

This block is a 16-bit up-counting timer/counter that sits in a microcontroller's register space. Software sees an 8-bit control register, a count register and a reload register, each reached one byte at a time. While running, the count advances on an internal clock-enable tick or on falling edges of an external count pin. When the count passes the all-ones value it is refilled from the reload register and an overflow flag is raised.

A second pin, the reload trigger, can also refill the count on a falling edge when software enables it. This raises its own external flag, so an interrupt handler can read both flags and tell the causes apart. Both flags stay set until software clears them. When the timer is picked as a serial baud clock source, overflows pulse the receive or transmit baud tick instead of raising the overflow flag.

Top module: `arl_timer`

## Requirements
- R1: With the run bit (control bit 2) at 1 and the source-select bit (control bit 1) at 0, the count rises by one on each cycle where tick_en is 1, and the new value is readable after that clock edge.
- R2: An increment from 16'hFFFF loads the count with the reload register instead. In the same edge the overflow flag (control bit 7) is set, unless bit 5 or bit 4 is 1.
- R3: With the trigger-enable bit (control bit 3) at 1, a 1-to-0 change on reload_trig_i loads the count from the reload register and sets the external flag (control bit 6). This takes effect on the third rising clock edge after the change, and it does not depend on the run bit.
- R4: With the trigger-enable bit at 0, reload_trig_i changes neither the count nor the external flag.
- R5: Software cannot set either flag. A control write keeps a flag only where the written bit is 1 and the flag was already set. A hardware set in the same cycle as a clearing write leaves the flag at 1.
- R6: The receive-select bit (control bit 5) makes every overflow drive rx_baud_tick high for one cycle after the edge that reloads. The transmit-select bit (control bit 4) does the same for tx_baud_tick. While either bit is 1, the overflow flag is not set.
- R7: With the source-select bit at 1, the count rises once for each synchronized falling edge of count_pin_i, and tick_en is ignored.
- R8: With the run bit at 0, the count holds its value. Only software writes and trigger reloads change it.
- R9: Register addresses are 0 for control, 1 and 2 for the count low and high bytes, and 3 and 4 for the reload low and high bytes. A count byte write wins over an increment or reload in the same cycle.
- R10: After reset, every register reads 0 and both baud ticks are low. Control bit 0 is plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Internal count enable used in timer mode |
| reload_trig_i | input | 1 | Asynchronous reload trigger, falling-edge active |
| count_pin_i | input | 1 | Asynchronous count source, falling-edge active |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write address |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 8 | Read data, combinational from reg_raddr |
| rx_baud_tick | output | 1 | One-cycle overflow pulse for the serial receive clock |
| tx_baud_tick | output | 1 | One-cycle overflow pulse for the serial transmit clock |

## Verification
Register writes, increments, overflow reloads and flag changes all show up in the read data right after the edge that samples them. A pin falling edge lands on the third rising edge after the pin changes, because of the two synchronizer stages and the previous-sample flop. The baud ticks are registered and go high in the cycle after the reloading edge. The behavioural model steps its own pin pipeline once per edge, so its expected values follow these same latencies. The bench compares the model against the outputs 2 ns after each rising edge, and the directed checks read just after a falling edge, once all of a scenario's edges have passed.

// File: rtl/arl_timer_pkg.sv
package arl_timer_pkg;

    // Control register layout, most significant bit first.
    typedef struct packed {
        logic ovf_flag;
        logic ext_flag;
        logic rx_sel;
        logic tx_sel;
        logic ext_en;
        logic run;
        logic src_sel;
        logic aux_bit;
    } ctrl_t;

    localparam int CTRL_ADDR = 0;
    localparam int CNT_BASE  = 1;

    typedef struct packed {
        logic rx;
        logic tx;
    } baud_t;

endpackage

// File: rtl/arl_fall_sync.sv
module arl_fall_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
        prev_d = sync_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign fall = prev_q & ~sync_q[LAST];

    // A detected edge lasts one cycle only
    p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/arl_ctrl_reg.sv
module arl_ctrl_reg
    import arl_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       ovf_hit,
    input  logic       ext_hit,
    output ctrl_t      ctrl_q
);
    ctrl_t ctrl_d;
    ctrl_t wr;

    always_comb begin
        wr     = ctrl_t'(wdata);
        ctrl_d = ctrl_q;
        if (we) begin
            ctrl_d          = wr;
            // software may only clear flags
            ctrl_d.ovf_flag = ctrl_q.ovf_flag & wr.ovf_flag;
            ctrl_d.ext_flag = ctrl_q.ext_flag & wr.ext_flag;
        end
        // hardware set has the last word
        if (ovf_hit && !ctrl_q.rx_sel && !ctrl_q.tx_sel)
            ctrl_d.ovf_flag = 1'b1;
        if (ext_hit)
            ctrl_d.ext_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.ovf_flag && !(we && !wdata[7]) |=> ctrl_q.ovf_flag);

    p_no_sw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.ext_flag && !ext_hit |=> !ctrl_q.ext_flag);

    p_baud_suppress_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.ovf_flag && (ctrl_q.rx_sel || ctrl_q.tx_sel) |=> !ctrl_q.ovf_flag);

    p_ext_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_hit |=> ctrl_q.ext_flag);

endmodule

// File: rtl/arl_count_core.sv
module arl_count_core
    import arl_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             ext_load,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [7:0]       wdata,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] reload_q,
    output logic             ovf_hit
);
    localparam int LANES    = CNT_W / 8;
    localparam int RLD_BASE = CNT_BASE + LANES;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
    } core_t;

    core_t st_d, st_q;
    logic  cnt_wr;

    always_comb begin
        st_d    = st_q;
        cnt_wr  = 1'b0;
        ovf_hit = inc & (&st_q.cnt);
        if (ovf_hit || ext_load)
            st_d.cnt = st_q.rld;
        else if (inc)
            st_d.cnt = st_q.cnt + 1'b1;
        for (int k = 0; k < LANES; k++) begin
            if (we && int'(addr) == CNT_BASE + k) begin
                st_d.cnt[8*k +: 8] = wdata;
                st_d.cnt           = {st_q.cnt[CNT_W-1:0]};
                st_d.cnt[8*k +: 8] = wdata;
                cnt_wr             = 1'b1;
            end
            if (we && int'(addr) == RLD_BASE + k)
                st_d.rld[8*k +: 8] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_q  = st_q.cnt;
    assign reload_q = st_q.rld;

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !(&count_q) && !ext_load && !cnt_wr |=> count_q == $past(count_q) + 1'b1);

    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_hit || ext_load) && !cnt_wr |=> count_q == $past(reload_q));

    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !inc && !ext_load && !cnt_wr |=> $stable(count_q));

    p_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we && int'(addr) == CNT_BASE |=> count_q[7:0] == $past(wdata));

endmodule

// File: rtl/arl_timer.sv
module arl_timer
    import arl_timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int AW          = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          reload_trig_i,
    input  logic          count_pin_i,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_waddr,
    input  logic [7:0]    reg_wdata,
    input  logic [AW-1:0] reg_raddr,
    output logic [7:0]    reg_rdata,
    output logic          rx_baud_tick,
    output logic          tx_baud_tick
);
    localparam int LANES    = CNT_W / 8;
    localparam int RLD_BASE = CNT_BASE + LANES;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] count_q, reload_q;
    logic             trig_fall, pin_fall;
    logic             inc, ext_load, ovf_hit;
    baud_t            baud_d, baud_q;

    arl_fall_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk(clk), .rst_n(rst_n), .din(reload_trig_i), .fall(trig_fall)
    );

    arl_fall_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .din(count_pin_i), .fall(pin_fall)
    );

    always_comb begin
        inc      = ctrl_q.run & (ctrl_q.src_sel ? pin_fall : tick_en);
        ext_load = ctrl_q.ext_en & trig_fall;
        baud_d.rx = ovf_hit & ctrl_q.rx_sel;
        baud_d.tx = ovf_hit & ctrl_q.tx_sel;
    end

    arl_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .we(reg_we && int'(reg_waddr) == CTRL_ADDR),
        .wdata(reg_wdata), .ovf_hit(ovf_hit), .ext_hit(ext_load),
        .ctrl_q(ctrl_q)
    );

    arl_count_core #(.CNT_W(CNT_W), .AW(AW)) u_core (
        .clk(clk), .rst_n(rst_n), .inc(inc), .ext_load(ext_load),
        .we(reg_we), .addr(reg_waddr), .wdata(reg_wdata),
        .count_q(count_q), .reload_q(reload_q), .ovf_hit(ovf_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) baud_q <= '0;
        else        baud_q <= baud_d;
    end

    assign rx_baud_tick = baud_q.rx;
    assign tx_baud_tick = baud_q.tx;

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_raddr) == CTRL_ADDR)
            reg_rdata = ctrl_q;
        for (int k = 0; k < LANES; k++) begin
            if (int'(reg_raddr) == CNT_BASE + k) reg_rdata = count_q[8*k +: 8];
            if (int'(reg_raddr) == RLD_BASE + k) reg_rdata = reload_q[8*k +: 8];
        end
    end

    p_rx_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_baud_tick |-> $past(ctrl_q.rx_sel));

    p_tx_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_baud_tick |-> $past(ctrl_q.tx_sel));

    p_trig_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.ext_en && !ctrl_q.ext_flag && !(reg_we && int'(reg_waddr) == CTRL_ADDR)
        |=> !ctrl_q.ext_flag);

endmodule

// File: tb/tb_arl_timer.sv
module tb_arl_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, reload_trig_i = 1'b1, count_pin_i = 1'b1;
    logic       reg_we = 1'b0;
    logic [2:0] reg_waddr = '0, reg_raddr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rx_baud_tick, tx_baud_tick;

    int checks = 0;
    int errors = 0;
    bit dir_rd = 1'b0;

    always #4 clk = ~clk;

    arl_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .reload_trig_i(reload_trig_i), .count_pin_i(count_pin_i),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .rx_baud_tick(rx_baud_tick), .tx_baud_tick(tx_baud_tick)
    );

    // behavioural reference state
    logic [7:0]  m_ctrl, n_ctrl;
    logic [15:0] m_cnt, n_cnt, m_rld, n_rld;
    logic        t1, t2, t3, c1, c2, c3, m_rx, m_tx;
    logic        tf, cf, m_inc, ov, ex;
    logic [7:0]  exp_rd;
    string       tag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_cnt = 0; m_rld = 0;
            t1 = 0; t2 = 0; t3 = 0; c1 = 0; c2 = 0; c3 = 0;
            m_rx = 0; m_tx = 0;
        end else begin
            tf = t3 & ~t2;
            cf = c3 & ~c2;
            t3 = t2; t2 = t1; t1 = reload_trig_i;
            c3 = c2; c2 = c1; c1 = count_pin_i;
            m_inc = m_ctrl[2] && (m_ctrl[1] ? cf : tick_en);
            ov = m_inc && (m_cnt == 16'hFFFF);
            ex = m_ctrl[3] && tf;
            m_rx = ov && m_ctrl[5];
            m_tx = ov && m_ctrl[4];
            n_ctrl = m_ctrl;
            n_rld = m_rld;
            n_cnt = m_cnt;
            if (ov || ex) n_cnt = m_rld;
            else if (m_inc) n_cnt = m_cnt + 16'd1;
            if (reg_we) begin
                case (reg_waddr)
                    3'd0: begin
                        n_ctrl[5:0] = reg_wdata[5:0];
                        n_ctrl[7] = m_ctrl[7] & reg_wdata[7];
                        n_ctrl[6] = m_ctrl[6] & reg_wdata[6];
                    end
                    3'd1: n_cnt = {m_cnt[15:8], reg_wdata};
                    3'd2: n_cnt = {reg_wdata, m_cnt[7:0]};
                    3'd3: n_rld[7:0] = reg_wdata;
                    3'd4: n_rld[15:8] = reg_wdata;
                    default: ;
                endcase
            end
            if (ov && !m_ctrl[5] && !m_ctrl[4]) n_ctrl[7] = 1'b1;
            if (ex) n_ctrl[6] = 1'b1;
            m_ctrl = n_ctrl; m_cnt = n_cnt; m_rld = n_rld;
        end
        #2;
        case (reg_raddr)
            3'd0: begin exp_rd = m_ctrl;       tag = "R5"; end
            3'd1: begin exp_rd = m_cnt[7:0];   tag = "R1"; end
            3'd2: begin exp_rd = m_cnt[15:8];  tag = "R2"; end
            3'd3: begin exp_rd = m_rld[7:0];   tag = "R9"; end
            3'd4: begin exp_rd = m_rld[15:8];  tag = "R9"; end
            default: begin exp_rd = 8'h00;     tag = "R10"; end
        endcase
        checks++;
        if (reg_rdata !== exp_rd) begin
            errors++;
            $display("FAIL %s model addr %0d: actual %h expected %h", tag, reg_raddr, reg_rdata, exp_rd);
        end
        checks++;
        if ({rx_baud_tick, tx_baud_tick} !== {m_rx, m_tx}) begin
            errors++;
            $display("FAIL R6 baud ticks: actual %b%b expected %b%b", rx_baud_tick, tx_baud_tick, m_rx, m_tx);
        end
    end

    // rotate the read address when no directed read is active
    always @(posedge clk) begin
        #3;
        if (!dir_rd) reg_raddr = (reg_raddr == 3'd4) ? 3'd0 : reg_raddr + 3'd1;
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic chk(input logic [2:0] a, input logic [7:0] e, input string r);
        @(negedge clk);
        dir_rd = 1'b1; reg_raddr = a;
        #1;
        checks++;
        if (reg_rdata !== e) begin
            errors++;
            $display("FAIL %s addr %0d: actual %h expected %h", r, a, reg_rdata, e);
        end
        dir_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk(3'd0, 8'h00, "R10");
        chk(3'd1, 8'h00, "R10");
        chk(3'd4, 8'h00, "R10");
        // R9 byte writes
        wr(3'd3, 8'hF0); wr(3'd4, 8'hFF);
        wr(3'd1, 8'hFA); wr(3'd2, 8'hFF);
        chk(3'd2, 8'hFF, "R9");
        chk(3'd3, 8'hF0, "R9");
        // R8 stopped timer holds
        wr(3'd0, 8'h01);
        ticks(4);
        chk(3'd1, 8'hFA, "R8");
        chk(3'd0, 8'h01, "R10");
        // R1 counting
        wr(3'd0, 8'h04);
        ticks(3);
        chk(3'd1, 8'hFD, "R1");
        // R2 rollover: FD FE FF -> F0 F1 F2
        ticks(5);
        chk(3'd1, 8'hF2, "R2");
        chk(3'd2, 8'hFF, "R2");
        chk(3'd0, 8'h84, "R2");
        // R5 writing 1 keeps, writing 0 clears, sw cannot set
        wr(3'd0, 8'hC4);
        chk(3'd0, 8'h84, "R5");
        wr(3'd0, 8'h04);
        chk(3'd0, 8'h04, "R5");
        wr(3'd0, 8'hC4);
        chk(3'd0, 8'h04, "R5");
        // R6 receive and transmit baud sources
        wr(3'd0, 8'h24); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
        ticks(1);
        chk(3'd0, 8'h24, "R6");
        chk(3'd1, 8'hF0, "R6");
        wr(3'd0, 8'h14); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
        ticks(1);
        chk(3'd0, 8'h14, "R6");
        // R5 collision: set wins over clear
        wr(3'd0, 8'h04); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = 3'd0; reg_wdata = 8'h04; tick_en = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; tick_en = 1'b0;
        chk(3'd0, 8'h84, "R5");
        // R4 trigger ignored when disabled
        wr(3'd0, 8'h04); wr(3'd1, 8'h34); wr(3'd2, 8'h12);
        repeat (4) @(negedge clk);
        reload_trig_i = 1'b0;
        repeat (4) @(negedge clk);
        reload_trig_i = 1'b1;
        chk(3'd1, 8'h34, "R4");
        chk(3'd0, 8'h04, "R4");
        // R3 enabled trigger, timer stopped
        wr(3'd0, 8'h08);
        repeat (3) @(negedge clk);
        reload_trig_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(3'd1, 8'hF0, "R3");
        chk(3'd0, 8'h48, "R3");
        reload_trig_i = 1'b1;
        // R7 counter mode, tick_en ignored
        wr(3'd0, 8'h06);
        @(negedge clk); tick_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            repeat (3) @(negedge clk);
            count_pin_i = 1'b0;
            repeat (3) @(negedge clk);
            count_pin_i = 1'b1;
        end
        tick_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(3'd1, 8'hF4, "R7");
        // R9 write beats increment
        wr(3'd0, 8'h04);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = 3'd1; reg_wdata = 8'h55; tick_en = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; tick_en = 1'b0;
        chk(3'd1, 8'h55, "R9");
        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            tick_en = $urandom_range(0, 1);
            if ($urandom_range(0, 7) == 0) reload_trig_i = ~reload_trig_i;
            if ($urandom_range(0, 5) == 0) count_pin_i = ~count_pin_i;
            reg_we = ($urandom_range(0, 15) == 0);
            reg_waddr = 3'($urandom_range(0, 4));
            reg_wdata = 8'($urandom);
            if (reg_waddr == 3'd2 || reg_waddr == 3'd4) reg_wdata = 8'hFF;
        end
        @(negedge clk);
        reg_we = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule